// File: doc/BRIEF.md
# Fragmenting Message Transmitter

This block sends one byte message to a remote agent through a slot-based transmit buffer in which every slot holds 32 bits. A request names the message length, a host address and a client address. The block then fetches the message bytes one at a time through a random-access byte read port. It cuts the message into fragments and writes each fragment to the buffer as a header word followed by packed payload words. After each fragment it raises a doorbell for the remote side.

The buffer reports its current free-slot count and its total depth on two inputs. The engine never writes a slot that the buffer has not reported as free. A remote-ready input shows whether the far side is alive. The engine waits for it at the start of each attempt and samples it again when each doorbell is raised. If a check fails or a wait times out, the attempt is abandoned and the whole message is restarted from byte zero. This repeats up to a bounded number of attempts, after which the block reports an error. If every fragment is accepted, the block reports done. Because a retry reads the message again, the bytes must stay readable at their addresses until done or error.

Top module: `frag_tx`

## Requirements
- R1: Each header word carries the last-fragment flag in bit 31, zeros in bits 30:25, the payload byte count (9 bits) in bits 24:16, the host address in bits 15:8 and the client address in bits 7:0.
- R2: A fragment carries min(remaining bytes, min(4 x depth, 511) - 4) bytes. Only the final fragment of a message has the last flag set.
- R3: A header word is written only after the free-slot count has been seen non-zero. While the count stays zero, no slot is written.
- R4: After its header, the payload of a fragment is not written until the free-slot count is at least ceil(length / 4).
- R5: Payload bytes are packed little-endian: the first byte of a word goes to bits 7:0. A partial final word carries its valid bytes in the low lanes and zeros in the unused high lanes.
- R6: The doorbell pulses for exactly one cycle per fragment, in the cycle after that fragment's last payload word. Its word count matches the header length.
- R7: If remote-ready is low in a doorbell cycle, the attempt fails. The next attempt resends the message from byte 0, starting with the first header.
- R8: Each attempt begins by waiting for remote-ready. If it stays low for TIMEOUT cycles, the attempt is used up and nothing is written.
- R9: At most MAX_TRIES attempts (default 5) are made per request. After the last one fails, error pulses for one cycle, busy falls and no further slot is written.
- R10: A header-space wait or payload-space wait that lasts TIMEOUT cycles aborts the current attempt.
- R11: A start with length 0, or while depth is below 2, raises error in the next cycle without writing any slot and without raising busy.
- R12: Done pulses for one cycle in the cycle after the final doorbell, when remote-ready was high at that doorbell. Busy is high from the accepted start until done or error, and done and error never pulse together.
- R13: A start pulse while busy is ignored. The message in flight continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| msg_len | input | LEN_W | Message length in bytes |
| host_addr | input | 8 | Host address placed in headers |
| client_addr | input | 8 | Client address placed in headers |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: message fully sent |
| error | output | 1 | One-cycle pulse: request rejected or all attempts failed |
| byte_addr | output | LEN_W | Offset of the message byte being fetched |
| byte_data | input | 8 | Message byte at byte_addr, same cycle |
| slot_free | input | SLOT_W | Free slots in the transmit buffer |
| slot_depth | input | SLOT_W | Total slots in the transmit buffer |
| slot_wr | output | 1 | Write strobe for one slot |
| slot_word | output | 32 | Word written with slot_wr |
| doorbell | output | 1 | One-cycle pulse after each fragment |
| remote_ready | input | 1 | Remote side alive and accepting |

## Verification
Most internal faults show up at the buffer port within one fragment. A wrong byte counter or lane index shifts or drops bytes in the very next payload word. A wrong length computation puts a bad count in the next header, and the doorbell then follows a word count that disagrees with it. A broken space wait shows as a slot write while the reported free count is too small, in the same cycle it happens. A broken retry counter only shows at the end of a failing request: done or error arrives an attempt too early or too late, which is hundreds of cycles after the start because each attempt waits out its own timeout. The bench therefore times the whole failing request, not only single words.

// File: rtl/frag_tx_pkg.sv
package frag_tx_pkg;

  localparam int HDR_LEN_LSB  = 16;
  localparam int HDR_LEN_BITS = 9;
  localparam int HDR_LEN_CAP  = (1 << HDR_LEN_BITS) - 1;
  localparam int SLOT_BYTES   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDY,
    ST_HSPACE,
    ST_HWR,
    ST_PSPACE,
    ST_PACK,
    ST_PWR,
    ST_BELL
  } tx_state_e;

  // Header word: last flag, payload length, host, client.
  function automatic logic [31:0] hdr_pack(input logic last,
                                           input logic [HDR_LEN_BITS-1:0] len,
                                           input logic [7:0] host,
                                           input logic [7:0] client);
    hdr_pack = {last, 6'b0, len, host, client};
  endfunction

  // Slots needed to carry len payload bytes.
  function automatic int unsigned slots_for(input int unsigned len);
    slots_for = (len + SLOT_BYTES - 1) / SLOT_BYTES;
  endfunction

  // Largest payload per fragment: one slot kept for the header.
  function automatic int unsigned max_payload(input int unsigned depth);
    int unsigned cap;
    cap = depth * SLOT_BYTES;
    if (cap > HDR_LEN_CAP) cap = HDR_LEN_CAP;
    max_payload = (cap > SLOT_BYTES) ? cap - SLOT_BYTES : 0;
  endfunction

endpackage

// File: rtl/frag_tx_sizer.sv
module frag_tx_sizer
  import frag_tx_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int SLOT_W = 8
) (
  input  logic [LEN_W-1:0]        remaining,
  input  logic [SLOT_W-1:0]       depth,
  input  logic [7:0]              host,
  input  logic [7:0]              client,
  output logic [HDR_LEN_BITS-1:0] frag_len,
  output logic [SLOT_W-1:0]       frag_slots,
  output logic [31:0]             header
);
  int unsigned max_pl;
  int unsigned rem_i;
  int unsigned len_i;
  logic        last;

  always_comb begin
    max_pl = max_payload(32'(depth));
    rem_i  = 32'(remaining);
    last   = (rem_i <= max_pl);
    len_i  = last ? rem_i : max_pl;
    frag_len   = HDR_LEN_BITS'(len_i);
    frag_slots = SLOT_W'(slots_for(len_i));
    header     = hdr_pack(last, frag_len, host, client);
  end
endmodule

// File: rtl/frag_tx_packer.sv
module frag_tx_packer #(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     load,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]               byte_in,
  output logic [8*LANES-1:0]       word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        lane_q <= '0;
      else if (load && lane == g)
        lane_q <= byte_in;
    end
    assign word[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/frag_tx_timer.sv
module frag_tx_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expired)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/frag_tx.sv
module frag_tx
  import frag_tx_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int SLOT_W    = 8,
  parameter int TIMEOUT   = 64,
  parameter int MAX_TRIES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic [7:0]        host_addr,
  input  logic [7:0]        client_addr,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [LEN_W-1:0]  byte_addr,
  input  logic [7:0]        byte_data,
  input  logic [SLOT_W-1:0] slot_free,
  input  logic [SLOT_W-1:0] slot_depth,
  output logic              slot_wr,
  output logic [31:0]       slot_word,
  output logic              doorbell,
  input  logic              remote_ready
);
  localparam int TRY_W  = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam int LANE_W = $clog2(SLOT_BYTES);

  tx_state_e              state;
  logic [LEN_W-1:0]       len_q, addr_q, remaining_q;
  logic [7:0]             host_q, client_q;
  logic [HDR_LEN_BITS-1:0] frag_left_q;
  logic [LANE_W-1:0]      lane_q;
  logic [31:0]            hdr_q;
  logic [SLOT_W-1:0]      need_q;
  logic [TRY_W-1:0]       tries_q;
  logic                   done_q, err_q;

  logic [HDR_LEN_BITS-1:0] sz_len;
  logic [SLOT_W-1:0]       sz_slots;
  logic [31:0]             sz_hdr;
  logic [31:0]             pack_word;
  logic                    wait_run, wait_expired;

  // Named internal events, used by the checker.
  logic ev_hdr_wr, ev_pl_wr, ev_fail, ev_last_try, ev_accept, ev_reject;

  assign ev_hdr_wr   = (state == ST_HWR);
  assign ev_pl_wr    = (state == ST_PWR);
  assign ev_last_try = (tries_q == TRY_W'(MAX_TRIES - 1));
  assign ev_accept   = (state == ST_IDLE) && start && (msg_len != '0) && (slot_depth >= SLOT_W'(2));
  assign ev_reject   = (state == ST_IDLE) && start && !ev_accept;
  assign ev_fail     = wait_expired || ((state == ST_BELL) && !remote_ready);

  assign wait_run = ((state == ST_RDY)    && !remote_ready) ||
                    ((state == ST_HSPACE) && (slot_free == '0)) ||
                    ((state == ST_PSPACE) && (slot_free < need_q));

  frag_tx_sizer #(.LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_sizer (
    .remaining  (remaining_q),
    .depth      (slot_depth),
    .host       (host_q),
    .client     (client_q),
    .frag_len   (sz_len),
    .frag_slots (sz_slots),
    .header     (sz_hdr)
  );

  frag_tx_packer #(.LANES(SLOT_BYTES)) u_packer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ev_pl_wr || ev_fail),
    .load    (state == ST_PACK),
    .lane    (lane_q),
    .byte_in (byte_data),
    .word    (pack_word)
  );

  frag_tx_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wait_run),
    .expired (wait_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      len_q       <= '0;
      addr_q      <= '0;
      remaining_q <= '0;
      host_q      <= '0;
      client_q    <= '0;
      frag_left_q <= '0;
      lane_q      <= '0;
      hdr_q       <= '0;
      need_q      <= '0;
      tries_q     <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (ev_fail) begin
        if (ev_last_try) begin
          state <= ST_IDLE;
          err_q <= 1'b1;
        end else begin
          tries_q     <= tries_q + 1'b1;
          state       <= ST_RDY;
          addr_q      <= '0;
          remaining_q <= len_q;
          lane_q      <= '0;
        end
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (ev_reject) err_q <= 1'b1;
            if (ev_accept) begin
              len_q       <= msg_len;
              remaining_q <= msg_len;
              host_q      <= host_addr;
              client_q    <= client_addr;
              addr_q      <= '0;
              lane_q      <= '0;
              tries_q     <= '0;
              state       <= ST_RDY;
            end
          end
          ST_RDY: if (remote_ready) state <= ST_HSPACE;
          ST_HSPACE: begin
            if (slot_free != '0) begin
              hdr_q       <= sz_hdr;
              frag_left_q <= sz_len;
              need_q      <= sz_slots;
              state       <= ST_HWR;
            end
          end
          ST_HWR: state <= ST_PSPACE;
          ST_PSPACE: if (slot_free >= need_q) state <= ST_PACK;
          ST_PACK: begin
            addr_q      <= addr_q + 1'b1;
            remaining_q <= remaining_q - 1'b1;
            frag_left_q <= frag_left_q - 1'b1;
            lane_q      <= lane_q + 1'b1;
            if (lane_q == LANE_W'(SLOT_BYTES - 1) || frag_left_q == HDR_LEN_BITS'(1))
              state <= ST_PWR;
          end
          ST_PWR: begin
            lane_q <= '0;
            state  <= (frag_left_q == '0) ? ST_BELL : ST_PACK;
          end
          ST_BELL: begin
            if (remaining_q == '0) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= ST_HSPACE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign byte_addr = addr_q;
  assign slot_wr   = ev_hdr_wr || ev_pl_wr;
  assign slot_word = ev_hdr_wr ? hdr_q : pack_word;
  assign doorbell  = (state == ST_BELL);
endmodule

// File: rtl/frag_tx_chk.sv
module frag_tx_chk #(
  parameter int SLOT_W    = 8,
  parameter int TRY_W     = 3,
  parameter int MAX_TRIES = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              slot_wr,
  input logic [31:0]       slot_word,
  input logic              doorbell,
  input logic [SLOT_W-1:0] slot_free,
  input logic              remote_ready,
  input logic              ev_hdr_wr,
  input logic [TRY_W-1:0]  tries_q
);
  logic [9:0] wcnt;
  logic [8:0] hlen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
      hlen <= '0;
    end else if (ev_hdr_wr) begin
      wcnt <= '0;
      hlen <= slot_word[24:16];
    end else if (slot_wr) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  a_r3_hdr_space: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr_wr |-> $past(slot_free) != '0);

  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr_wr |-> (slot_word[24:16] != 9'd0) && (slot_word[24:16] <= 9'd507));

  a_r1_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr_wr |-> slot_word[30:25] == 6'd0);

  a_r6_bell_words: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> wcnt == (({1'b0, hlen} + 10'd3) >> 2));

  a_r6_bell_single: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell);

  a_r12_done_after_bell: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(doorbell) && $past(remote_ready));

  a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  a_r9_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q < TRY_W'(MAX_TRIES));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !slot_wr && !doorbell);
endmodule

bind frag_tx frag_tx_chk #(
  .SLOT_W    (SLOT_W),
  .TRY_W     (TRY_W),
  .MAX_TRIES (MAX_TRIES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .error        (error),
  .slot_wr      (slot_wr),
  .slot_word    (slot_word),
  .doorbell     (doorbell),
  .slot_free    (slot_free),
  .remote_ready (remote_ready),
  .ev_hdr_wr    (ev_hdr_wr),
  .tries_q      (tries_q)
);

// File: tb/frag_tx_tb.sv
`timescale 1ns/1ps
module frag_tx_tb;
  localparam int LEN_W = 16;
  localparam int SLOT_W = 8;
  localparam int TIMEOUT = 64;
  localparam int MAX_TRIES = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] msg_len = '0;
  logic [7:0] host_addr = '0, client_addr = '0;
  logic busy, done, error, slot_wr, doorbell;
  logic [LEN_W-1:0] byte_addr;
  logic [7:0] byte_data;
  logic [SLOT_W-1:0] slot_free, slot_depth;
  logic [31:0] slot_word;
  logic remote_ready = 1'b1;

  always #2.5 clk = ~clk;

  logic [7:0] msg_mem [0:2047];
  assign byte_data = msg_mem[byte_addr[10:0]];

  // Buffer model
  logic [SLOT_W-1:0] depth_cfg = 8'd4;
  logic [SLOT_W-1:0] free_lvl = '0;
  logic free_load = 1'b0;
  logic [SLOT_W-1:0] free_load_val = '0;
  logic cap_clr = 1'b0;
  logic [31:0] got [0:1023];
  int got_n = 0;
  int bells = 0;
  assign slot_free = free_lvl;
  assign slot_depth = depth_cfg;

  always @(posedge clk) begin
    if (free_load) free_lvl <= free_load_val;
    else if (slot_wr) free_lvl <= free_lvl - 1'b1;
    else if (doorbell) free_lvl <= depth_cfg;
    if (cap_clr) begin
      got_n <= 0;
      bells <= 0;
    end else begin
      if (slot_wr) begin
        got[got_n[9:0]] <= slot_word;
        got_n <= got_n + 1;
      end
      if (doorbell) bells <= bells + 1;
    end
  end

  frag_tx #(.LEN_W(LEN_W), .SLOT_W(SLOT_W), .TIMEOUT(TIMEOUT), .MAX_TRIES(MAX_TRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
    .host_addr(host_addr), .client_addr(client_addr), .busy(busy), .done(done),
    .error(error), .byte_addr(byte_addr), .byte_data(byte_data),
    .slot_free(slot_free), .slot_depth(slot_depth), .slot_wr(slot_wr),
    .slot_word(slot_word), .doorbell(doorbell), .remote_ready(remote_ready));

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_w [0:1023];
  int exp_n;
  int exp_frags;
  int end_cycles;
  logic end_done, end_err;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Expected stream computed from R1, R2 and R5.
  task automatic build_exp(input int len, input int depth, input int host, input int client);
    int cap, maxpl, off, rem, fl;
    logic [31:0] w;
    cap = depth * 4;
    if (cap > 511) cap = 511;
    maxpl = cap - 4;
    exp_n = 0; exp_frags = 0; off = 0; rem = len;
    while (rem > 0) begin
      fl = (rem < maxpl) ? rem : maxpl;
      exp_w[exp_n] = {(fl == rem), 6'd0, 9'(fl), 8'(host), 8'(client)};
      exp_n++; exp_frags++;
      for (int i = 0; i < (fl + 3) / 4; i++) begin
        w = '0;
        for (int b = 0; b < 4; b++)
          if (i * 4 + b < fl) w[8*b +: 8] = msg_mem[off + i * 4 + b];
        exp_w[exp_n] = w;
        exp_n++;
      end
      off += fl; rem -= fl;
    end
  endtask

  task automatic set_free(input int v);
    @(negedge clk); free_load = 1'b1; free_load_val = SLOT_W'(v);
    @(negedge clk); free_load = 1'b0;
  endtask

  task automatic clear_cap();
    @(negedge clk); cap_clr = 1'b1;
    @(negedge clk); cap_clr = 1'b0;
  endtask

  task automatic issue(input int len, input int host, input int client);
    @(negedge clk);
    start = 1'b1; msg_len = LEN_W'(len); host_addr = 8'(host); client_addr = 8'(client);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input int limit);
    end_done = 0; end_err = 0; end_cycles = 1;
    while (!done && !error && end_cycles < limit) begin
      @(negedge clk); end_cycles++;
    end
    end_done = done; end_err = error;
  endtask

  task automatic cmp_stream(input int base, input string req);
    for (int i = 0; i < exp_n; i++)
      check(got[base + i] === exp_w[i], req, got[base + i], exp_w[i]);
  endtask

  task automatic t_reset();
    check(!busy && !done && !error, "R12 reset idle", {busy, done, error}, 0);
    check(!slot_wr && !doorbell, "R6 reset quiet", {slot_wr, doorbell}, 0);
  endtask

  task automatic t_msg(input int len, input int depth, input int host, input int client, input string req);
    depth_cfg = SLOT_W'(depth);
    set_free(depth);
    clear_cap();
    build_exp(len, depth, host, client);
    issue(len, host, client);
    check(busy, "R12 busy after start", busy, 1);
    wait_end(20000);
    check(end_done && !end_err, {req, " done"}, {end_done, end_err}, 2);
    @(negedge clk);
    check(!done && !busy, "R12 done one cycle", {done, busy}, 0);
    check(got_n == exp_n, {req, " word count"}, got_n, exp_n);
    check(bells == exp_frags, "R6 doorbells per fragment", bells, exp_frags);
    cmp_stream(0, req);
  endtask

  task automatic t_reject();
    depth_cfg = 8'd4;
    clear_cap();
    @(negedge clk); start = 1'b1; msg_len = '0;
    @(negedge clk); start = 1'b0;
    check(error && !busy, "R11 zero length error", {error, busy}, 2);
    @(negedge clk);
    check(!error, "R11 error one cycle", error, 0);
    depth_cfg = 8'd1;
    @(negedge clk); start = 1'b1; msg_len = 16'd4;
    @(negedge clk); start = 1'b0;
    check(error && !busy, "R11 small depth error", {error, busy}, 2);
    repeat (3) @(negedge clk);
    check(got_n == 0, "R11 no writes", got_n, 0);
    depth_cfg = 8'd4;
  endtask

  task automatic t_hdr_space();
    depth_cfg = 8'd4;
    set_free(0);
    clear_cap();
    build_exp(5, 4, 8'h11, 8'h22);
    issue(5, 8'h11, 8'h22);
    repeat (20) @(negedge clk);
    check(got_n == 0 && busy, "R3 no write without space", got_n, 0);
    set_free(4);
    wait_end(2000);
    check(end_done, "R3 completes after space", end_done, 1);
    cmp_stream(0, "R3 stream");
  endtask

  task automatic t_pl_space();
    depth_cfg = 8'd4;
    set_free(2);
    clear_cap();
    build_exp(12, 4, 8'h33, 8'h44);
    issue(12, 8'h33, 8'h44);
    repeat (20) @(negedge clk);
    check(got_n == 1, "R4 only header before payload space", got_n, 1);
    set_free(3);
    wait_end(2000);
    check(end_done && got_n == 4, "R4 payload after space", got_n, 4);
    cmp_stream(0, "R4 stream");
  endtask

  task automatic t_ready_fail();
    depth_cfg = 8'd4;
    set_free(0);
    clear_cap();
    build_exp(7, 4, 8'h55, 8'h66);
    issue(7, 8'h55, 8'h66);
    repeat (3) @(negedge clk);
    remote_ready = 1'b0;
    set_free(4);
    for (int i = 0; i < 200 && bells < 1; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(busy && !error, "R7 retry pending", {busy, error}, 2);
    remote_ready = 1'b1;
    wait_end(2000);
    check(end_done, "R7 second attempt done", end_done, 1);
    check(got_n == 2 * exp_n, "R7 resent whole message", got_n, 2 * exp_n);
    check(bells == 2, "R7 two doorbells", bells, 2);
    cmp_stream(0, "R7 first attempt");
    cmp_stream(exp_n, "R7 resend from byte 0");
  endtask

  task automatic t_ready_exhaust();
    depth_cfg = 8'd4;
    set_free(4);
    clear_cap();
    remote_ready = 1'b0;
    issue(8, 1, 2);
    wait_end(2000);
    check(end_err && !end_done, "R9 error after tries", {end_err, end_done}, 2);
    check(end_cycles >= MAX_TRIES * TIMEOUT - 2 && end_cycles <= MAX_TRIES * TIMEOUT + 10,
          "R8 timeout per attempt", end_cycles, MAX_TRIES * TIMEOUT);
    @(negedge clk);
    check(!busy && got_n == 0, "R9 idle and no writes", got_n, 0);
    remote_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(got_n == 0 && bells == 0, "R9 nothing after error", got_n + bells, 0);
  endtask

  task automatic t_space_timeout();
    depth_cfg = 8'd4;
    set_free(0);
    clear_cap();
    issue(4, 3, 4);
    wait_end(2000);
    check(end_err, "R10 space timeout error", end_err, 1);
    check(end_cycles >= MAX_TRIES * TIMEOUT && end_cycles <= MAX_TRIES * (TIMEOUT + 2) + 10,
          "R10 attempts timed", end_cycles, MAX_TRIES * (TIMEOUT + 1));
    check(got_n == 0, "R10 no writes", got_n, 0);
  endtask

  task automatic t_busy_start();
    depth_cfg = 8'd4;
    set_free(4);
    clear_cap();
    build_exp(30, 4, 8'h77, 8'h88);
    issue(30, 8'h77, 8'h88);
    repeat (6) @(negedge clk);
    @(negedge clk); start = 1'b1; msg_len = 16'd3; host_addr = 8'hEE; client_addr = 8'hFF;
    @(negedge clk); start = 1'b0;
    wait_end(2000);
    check(end_done, "R13 first request done", end_done, 1);
    repeat (5) @(negedge clk);
    check(got_n == exp_n && !busy, "R13 start ignored", got_n, exp_n);
    cmp_stream(0, "R13 stream");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) msg_mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_msg(1, 4, 8'hA1, 8'hB2, "R5 single byte");
    t_msg(5, 4, 8'h01, 8'h02, "R5 partial word");
    t_msg(12, 4, 8'h10, 8'h20, "R2 exact fragment");
    t_msg(30, 4, 8'h31, 8'h41, "R2 three fragments");
    t_msg(600, 127, 8'h5A, 8'hA5, "R2 depth 127");
    t_msg(1100, 200, 8'hC3, 8'h3C, "R1 capped at 507");
    check(got[0][24:16] == 9'd507 && got[0][31] == 1'b0, "R1 first header",
          got[0], {1'b0, 6'd0, 9'd507, 8'hC3, 8'h3C});
    t_reject();
    t_hdr_space();
    t_pl_space();
    t_ready_fail();
    t_ready_exhaust();
    t_space_timeout();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule